// File: doc/BRIEF.md
# Strobed Input Port with Buffer-Full and Interrupt Handshake

This block is one parallel input port that takes a byte from a peripheral under a strobe handshake and holds it until the host reads it. The peripheral places a value on its data pins and pulses an active-low strobe. The start of that pulse marks the holding buffer as occupied, and the end of the pulse loads the buffer. Once the strobe is back high, the block raises an interrupt request, provided the host has enabled interrupts. The host answers with a read. The interrupt drops as soon as the read begins, and the buffer-full flag drops once the read has finished.

The strobe and the qualified host read arrive without a clock relationship to the port. Both pass through synchronizer chains of `SYNC_STAGES` flops. The peripheral data travels through a delay chain of the same length, so the captured value is the one present when the raw strobe was first seen high. Edges are found in the port clock domain.

The buffer-full flag is the port's back-pressure signal. The peripheral should strobe only while the flag is low. A strobe that arrives while the flag is high still loads the buffer, and the unread value is lost. There is no stall on the host side: the held value is always present on `host_data`. The host can use the interrupt, or it can poll the status word, which carries the flag, the interrupt and the enable bit.

Top module: `strobe_in_port`

## Requirements
- R1: While reset is asserted and after it is released, `buf_full` is 0, `irq_req` is 0 and `host_data` is 0.
- R2: `buf_full` goes to 1 exactly `SYNC_STAGES`+1 clock edges after `per_stb_n` falls (3 edges by default), and not before.
- R3: When `per_stb_n` returns high, the value on `per_data` at that moment appears on `host_data` `SYNC_STAGES`+1 edges later. `host_data` holds its value at all other times.
- R4: With `irq_en`=1, `irq_req` rises `SYNC_STAGES`+1 edges after `per_stb_n` returns high, while the buffer is full. If `irq_en` rises while the buffer is full, the strobe is high and no read is active, `irq_req` rises one edge later. `irq_req` is never 1 while `buf_full` is 0 or while the strobe is low.
- R5: A read begins when `host_rd_n`=0 together with `host_sel`=1. `irq_req` falls `SYNC_STAGES`+1 edges after the read begins, and `buf_full` stays 1 for as long as the read lasts.
- R6: `buf_full` falls `SYNC_STAGES`+1 edges after the read ends, which is when `host_rd_n` returns to 1. `irq_req` stays 0 after that.
- R7: While `irq_en`=0, `irq_req` is 0. Clearing `irq_en` while `irq_req` is 1 drops `irq_req` one edge later.
- R8: A read pulse on `host_rd_n` while `host_sel`=0 is ignored. `buf_full`, `irq_req` and `host_data` are unchanged after it.
- R9: A second strobe that arrives while `buf_full`=1 replaces the held value with the new one, and `buf_full` stays 1.
- R10: `status` carries the buffer-full flag in bit 2, the interrupt request in bit 1 and the `irq_en` input in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| per_data | input | W | Data from the peripheral |
| per_stb_n | input | 1 | Peripheral strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_sel | input | 1 | Select qualifier for the host read |
| irq_en | input | 1 | Interrupt enable from the register block |
| buf_full | output | 1 | Holding buffer contains unread data |
| irq_req | output | 1 | Interrupt request to the host |
| host_data | output | W | Held input value |
| status | output | 3 | Poll word {buf_full, irq_req, irq_en} |

## Verification
An event on the strobe or on the read input passes through the synchronizer and then one state register. Each such event therefore shows on `buf_full`, `irq_req` or `host_data` exactly three edges after it is driven. A change of `irq_en` shows on `irq_req` one edge later. The bench drives every input just after a falling clock edge. It samples outputs on falling edges: the second one after the stimulus, where the old value must still hold, and the third one, where the new value must appear. This pins each latency to the cycle. The sweep covers both enable settings across many data patterns, the qualified and unqualified reads, an overwrite, and a change of the enable while the buffer is full.

// File: rtl/strobe_in_pkg.sv
package strobe_in_pkg;

  // Decoded view of one synchronized control line
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } sip_edge_t;

  localparam int STATUS_W = 3;

  // Poll word layout: [2] buffer full, [1] interrupt, [0] enable
  function automatic logic [STATUS_W-1:0] sip_status(input logic full,
                                                      input logic irq,
                                                      input logic en);
    return {full, irq, en};
  endfunction

endpackage

// File: rtl/sip_sync.sv
module sip_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sip_edge.sv
module sip_edge
  import strobe_in_pkg::*;
#(
  parameter logic IDLE = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  output sip_edge_t ev
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= lvl;
  end

  assign ev.level = lvl;
  assign ev.rise  = lvl & ~prev_q;
  assign ev.fall  = ~lvl & prev_q;

endmodule

// File: rtl/sip_buffer.sv
module sip_buffer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         mark_full,
  input  logic         mark_empty,
  output logic [W-1:0] dout,
  output logic         full_q,
  output logic         full_nxt
);

  // Occupancy: a new strobe beats a finishing read in the same cycle
  always_comb begin
    full_nxt = full_q;
    if (mark_empty) full_nxt = 1'b0;
    if (mark_full)  full_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      dout   <= '0;
    end else begin
      full_q <= full_nxt;
      if (load) dout <= din;
    end
  end

endmodule

// File: rtl/sip_irq.sv
module sip_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic full_nxt,
  input  logic stb_high,
  input  logic rd_active,
  output logic irq_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= enable & full_nxt & stb_high & ~rd_active;
  end

endmodule

// File: rtl/strobe_in_port.sv
module strobe_in_port
  import strobe_in_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  per_data,
  input  logic          per_stb_n,
  input  logic          host_rd_n,
  input  logic          host_sel,
  input  logic          irq_en,
  output logic          buf_full,
  output logic          irq_req,
  output logic [W-1:0]  host_data,
  output logic [STATUS_W-1:0] status
);

  logic         stb_high_s;
  logic         rd_act_s;
  logic [W-1:0] data_s;
  sip_edge_t    stb_ev;
  sip_edge_t    rd_ev;
  logic         full_nxt;

  // Strobe idles high, so its chain resets to 1
  sip_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .d(per_stb_n), .q(stb_high_s)
  );

  // Qualified read request
  sip_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .d(~host_rd_n & host_sel), .q(rd_act_s)
  );

  // Data delayed to line up with the synchronized strobe
  sip_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_dly (
    .clk(clk), .rst_n(rst_n), .d(per_data), .q(data_s)
  );

  sip_edge #(.IDLE(1'b1)) u_stb_edge (
    .clk(clk), .rst_n(rst_n), .lvl(stb_high_s), .ev(stb_ev)
  );

  sip_edge #(.IDLE(1'b0)) u_rd_edge (
    .clk(clk), .rst_n(rst_n), .lvl(rd_act_s), .ev(rd_ev)
  );

  sip_buffer #(.W(W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load(stb_ev.rise), .din(data_s),
    .mark_full(stb_ev.fall), .mark_empty(rd_ev.fall),
    .dout(host_data), .full_q(buf_full), .full_nxt(full_nxt)
  );

  sip_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .enable(irq_en), .full_nxt(full_nxt),
    .stb_high(stb_ev.level), .rd_active(rd_ev.level),
    .irq_q(irq_req)
  );

  assign status = sip_status(buf_full, irq_req, irq_en);

endmodule

// File: rtl/sip_checks.sv
module sip_checks #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq_en,
  input logic         buf_full,
  input logic         irq_req,
  input logic [W-1:0] host_data,
  input logic         stb_rise,
  input logic         stb_fall,
  input logic         stb_high,
  input logic         rd_high,
  input logic         rd_fall
);

  p_full_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |=> buf_full);

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_rise |=> $stable(host_data));

  p_irq_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> buf_full);

  p_irq_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(stb_high));

  p_read_drops_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_high |=> !irq_req);

  p_read_end_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !stb_fall) |=> !buf_full);

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(irq_en));

endmodule

bind strobe_in_port sip_checks #(.W(W)) u_sip_checks (
  .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .buf_full(buf_full),
  .irq_req(irq_req), .host_data(host_data),
  .stb_rise(stb_ev.rise), .stb_fall(stb_ev.fall), .stb_high(stb_ev.level),
  .rd_high(rd_ev.level), .rd_fall(rd_ev.fall)
);

// File: tb/strobe_in_port_test.sv
module strobe_in_port_test;

  localparam int W   = 8;
  localparam int SS  = 2;
  localparam int LAT = SS + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] per_data = '0;
  logic         per_stb_n = 1'b1;
  logic         host_rd_n = 1'b1;
  logic         host_sel = 1'b0;
  logic         irq_en = 1'b0;
  logic         buf_full;
  logic         irq_req;
  logic [W-1:0] host_data;
  logic [2:0]   status;

  int checks = 0;
  int bad = 0;

  // Reference state, derived from the requirements
  logic         m_full = 1'b0;
  logic         m_irq = 1'b0;
  logic [W-1:0] m_data = '0;

  always #2 clk = ~clk;

  strobe_in_port #(.W(W), .SYNC_STAGES(SS)) uut (
    .clk(clk), .rst_n(rst_n), .per_data(per_data), .per_stb_n(per_stb_n),
    .host_rd_n(host_rd_n), .host_sel(host_sel), .irq_en(irq_en),
    .buf_full(buf_full), .irq_req(irq_req), .host_data(host_data),
    .status(status)
  );

  task automatic chk(input string rid, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rid, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Strobe pulse carrying value v; checks the exact edge of each output
  task automatic strobe(input logic [W-1:0] v);
    logic was_full;
    was_full = m_full;
    @(negedge clk);
    per_data  = v;
    per_stb_n = 1'b0;
    wait_n(LAT - 1);
    chk("R2 full not early", {31'd0, buf_full}, {31'd0, was_full});
    wait_n(1);
    m_full = 1'b1;
    m_irq  = 1'b0;
    chk("R2 full after strobe", {31'd0, buf_full}, 32'd1);
    chk("R4 no irq while strobe low", {31'd0, irq_req}, 32'd0);
    wait_n(2);
    per_stb_n = 1'b1;
    wait_n(LAT - 1);
    chk("R3 data not early", {24'd0, host_data}, {24'd0, m_data});
    wait_n(1);
    per_data = ~v;
    m_data = v;
    m_irq  = irq_en;
    chk("R3 captured data", {24'd0, host_data}, {24'd0, v});
    chk("R4 irq after strobe end", {31'd0, irq_req}, {31'd0, m_irq});
    chk("R10 status word", {29'd0, status}, {29'd0, m_full, m_irq, irq_en});
  endtask

  // Host read pulse, qualified or not
  task automatic host_read(input logic sel);
    @(negedge clk);
    host_rd_n = 1'b0;
    host_sel  = sel;
    wait_n(LAT);
    if (sel) begin
      m_irq = 1'b0;
      chk("R5 irq drops at read start", {31'd0, irq_req}, 32'd0);
      chk("R5 full held during read", {31'd0, buf_full}, {31'd0, m_full});
    end else begin
      chk("R8 irq kept on unselected read", {31'd0, irq_req}, {31'd0, m_irq});
      chk("R8 full kept on unselected read", {31'd0, buf_full}, {31'd0, m_full});
    end
    wait_n(2);
    host_rd_n = 1'b1;
    wait_n(LAT - 1);
    chk("R6 full not early", {31'd0, buf_full}, {31'd0, m_full});
    wait_n(1);
    host_sel = 1'b0;
    if (sel) m_full = 1'b0;
    chk(sel ? "R6 full clears after read" : "R8 full after unselected read",
        {31'd0, buf_full}, {31'd0, m_full});
    chk(sel ? "R6 irq stays low" : "R8 irq after unselected read",
        {31'd0, irq_req}, {31'd0, m_irq});
    chk("R8 data unchanged by read", {24'd0, host_data}, {24'd0, m_data});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    wait_n(3);
    chk("R1 full in reset", {31'd0, buf_full}, 32'd0);
    chk("R1 irq in reset", {31'd0, irq_req}, 32'd0);
    rst_n = 1'b1;
    wait_n(4);
    chk("R1 full after reset", {31'd0, buf_full}, 32'd0);
    chk("R1 irq after reset", {31'd0, irq_req}, 32'd0);
    chk("R1 data after reset", {24'd0, host_data}, 32'd0);
    chk("R10 status after reset", {29'd0, status}, 32'd0);

    // Sweep both enable settings over many data patterns
    for (int en = 0; en < 2; en++) begin
      irq_en = en[0];
      for (int i = 0; i < 12; i++) begin
        logic [W-1:0] v;
        v = W'((i * 53 + en * 29 + 7) & 255);
        if (i == 0) v = '0;
        if (i == 1) v = '1;
        strobe(v);
        if (en == 0) chk("R7 irq low when disabled", {31'd0, irq_req}, 32'd0);
        if (i % 3 == 0) host_read(1'b0);
        host_read(1'b1);
      end
    end

    // Overwrite while full
    irq_en = 1'b1;
    strobe(8'h3C);
    strobe(8'hA5);
    chk("R9 full stays set", {31'd0, buf_full}, 32'd1);
    chk("R9 latest value kept", {24'd0, host_data}, 32'hA5);

    // Enable toggled while full and strobe high
    @(negedge clk);
    irq_en = 1'b0;
    wait_n(1);
    chk("R7 irq drops one edge after disable", {31'd0, irq_req}, 32'd0);
    chk("R10 status with enable off", {29'd0, status}, 32'b100);
    wait_n(3);
    chk("R7 irq stays low", {31'd0, irq_req}, 32'd0);
    irq_en = 1'b1;
    wait_n(1);
    m_irq = 1'b1;
    chk("R4 irq on late enable", {31'd0, irq_req}, 32'd1);
    chk("R10 status all set", {29'd0, status}, 32'b111);
    host_read(1'b1);
    chk("R3 data after final read", {24'd0, host_data}, 32'hA5);

    wait_n(4);
    report();
  end

endmodule